// File: doc/BRIEF.md
# Bayer Mosaic to RGB Demosaic

This block turns a single-channel colour-filter mosaic into full RGB. The mosaic enters one sample per beat in raster order on a valid/ready stream. RGB words leave in the same raster order on a second valid/ready stream. Every output pixel is rebuilt from the 3x3 neighbourhood centred on it. For each colour, the output takes the average of the neighbours that carry that colour. A colour that matches the centre site is copied from the centre sample.

The block keeps a small ring of line memories. It starts emitting a row once the row below it has been stored, so the latency is about one row plus a few cycles. At the frame edges, a neighbour that falls outside the frame is read from the line or column one step inside the edge. This keeps the colour phase of the mosaic intact. At corners, the row reflection and the column reflection are applied together.

A stall on the output freezes the internal pipeline. The input then stops accepting samples once the line ring is full.

Top module: `bayer_demosaic`

## Requirements
- R1: The mosaic phase is red at row 0 column 0 and blue at row 1 column 1. At a red site (even row, even column) the output is: red = centre; green = (north + south + west + east) >> 2; blue = (sum of the four diagonal samples) >> 2. All averages truncate.
- R2: At a blue site (odd row, odd column) the output is: blue = centre; green = (north + south + west + east) >> 2; red = (sum of the four diagonals) >> 2.
- R3: At a green site, green = centre. On an even row: red = (west + east) >> 1 and blue = (north + south) >> 1. On an odd row: blue = (west + east) >> 1 and red = (north + south) >> 1.
- R4: A neighbour row -1 reads row 1, and row ROWS reads row ROWS-2. A neighbour column -1 reads column 1, and column COLS reads column COLS-2. Corner neighbours apply both reflections.
- R5: Each frame yields exactly ROWS*COLS output words in raster order. Each word is packed as red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Idle cycles on the input stream do not change the result.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R7: With the output blocked from reset, exactly 3*COLS input samples are accepted before in_ready drops. No sample is lost when the output resumes.
- R8: The first output word of a frame appears only after rows 0 and 1 of that frame have been fully accepted.
- R9: Frames may follow each other back to back. Each output frame depends only on the samples of its own input frame.
- R10: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Mosaic sample valid |
| in_ready | output | 1 | Block can accept a mosaic sample |
| in_data | input | DW | Mosaic sample |
| out_valid | output | 1 | RGB word valid |
| out_ready | input | 1 | Downstream accepts the RGB word |
| out_data | output | 3*DW | Packed RGB word {red, green, blue} |

## Verification
The hardest state to reach is a full line ring that meets a frozen pipeline. The writer is then three rows ahead of the engine, and the engine is stopped partway through its prefill of row 0. The bench reaches this state by holding out_ready low from the start of a frame while samples keep arriving. It then checks the accepted count, the held word and the full frame after release. A flat frame gives each colour phase its own constant value. Under correct reflection every output equals the same triple, while edge replication would break the border pixels. A back-to-back pair of unlike frames tests the frame turnover.

// File: rtl/bayer_pkg.sv
package bayer_pkg;
  // colour site of the centre sample, encoded {row odd, column odd}
  typedef enum logic [1:0] {
    SITE_RED   = 2'b00,
    SITE_GRN_R = 2'b01,
    SITE_GRN_B = 2'b10,
    SITE_BLU   = 2'b11
  } site_e;
endpackage

// File: rtl/bayer_line_mem.sv
module bayer_line_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 40,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  // R4: reflected column addresses never leave the line
  a_r4_col_in_range: assert property (@(posedge clk) disable iff (rst)
    re |-> (int'(raddr) < DEPTH));
endmodule

// File: rtl/bayer_kernel.sv
module bayer_kernel
  import bayer_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [2:0][2:0][DW-1:0] win,   // [row][col], row 0 on top, col 0 on the left
  input  site_e                   site,
  output logic [3*DW-1:0]         rgb
);
  localparam int SW = DW + 2;

  logic [SW-1:0] sum_cross, sum_diag, sum_h, sum_v;
  logic [DW-1:0] avg_cross, avg_diag, avg_h, avg_v, ctr;

  always_comb begin
    ctr       = win[1][1];
    sum_cross = SW'(win[0][1]) + SW'(win[2][1]) + SW'(win[1][0]) + SW'(win[1][2]);
    sum_diag  = SW'(win[0][0]) + SW'(win[0][2]) + SW'(win[2][0]) + SW'(win[2][2]);
    sum_h     = SW'(win[1][0]) + SW'(win[1][2]);
    sum_v     = SW'(win[0][1]) + SW'(win[2][1]);
    avg_cross = sum_cross[SW-1:2];
    avg_diag  = sum_diag[SW-1:2];
    avg_h     = sum_h[DW:1];
    avg_v     = sum_v[DW:1];
    unique case (site)
      SITE_RED:   rgb = {ctr, avg_cross, avg_diag};
      SITE_GRN_R: rgb = {avg_h, ctr, avg_v};
      SITE_GRN_B: rgb = {avg_v, ctr, avg_h};
      default:    rgb = {avg_diag, avg_cross, ctr};
    endcase
  end
endmodule

// File: rtl/bayer_demosaic.sv
module bayer_demosaic
  import bayer_pkg::*;
#(
  parameter int ROWS = 30,
  parameter int COLS = 40,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [3*DW-1:0] out_data
);
  localparam int RW    = $clog2(ROWS);
  localparam int CW    = $clog2(COLS + 2);
  localparam int MAW   = $clog2(COLS);
  localparam int NSLOT = 4;
  localparam int SLW   = $clog2(NSLOT);

  // ---------------- writer side ----------------
  logic [RW-1:0] wr_row;
  logic [CW-1:0] wr_col;
  logic          in_done;
  logic          in_fire;
  logic [RW-1:0] eng_row;
  logic [CW-1:0] eng_j;
  logic          frame_wrap;

  logic ahead_ok;
  assign ahead_ok = ({1'b0, wr_row} <= ({1'b0, eng_row} + (RW+1)'(2)));
  assign in_ready = !in_done && ahead_ok;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_row  <= '0;
      wr_col  <= '0;
      in_done <= 1'b0;
    end else begin
      if (frame_wrap) in_done <= 1'b0;
      if (in_fire) begin
        if (wr_col == CW'(COLS - 1)) begin
          wr_col <= '0;
          if (wr_row == RW'(ROWS - 1)) begin
            wr_row  <= '0;
            in_done <= 1'b1;
          end else begin
            wr_row <= wr_row + 1'b1;
          end
        end else begin
          wr_col <= wr_col + 1'b1;
        end
      end
    end
  end

  // ---------------- line ring ----------------
  logic          adv, issue, rows_ok;
  logic [RW-1:0] top_row, bot_row, need_row;
  logic [MAW-1:0] rd_col;
  logic [DW-1:0] rd [NSLOT];

  generate
    for (genvar m = 0; m < NSLOT; m++) begin : g_line
      bayer_line_mem #(.DW(DW), .DEPTH(COLS)) u_line (
        .clk   (clk),
        .rst   (rst),
        .we    (in_fire && (wr_row[SLW-1:0] == SLW'(m))),
        .waddr (wr_col[MAW-1:0]),
        .wdata (in_data),
        .re    (issue),
        .raddr (rd_col),
        .rdata (rd[m])
      );
    end
  endgenerate

  // ---------------- window engine ----------------
  assign adv      = !out_valid || out_ready;
  assign top_row  = (eng_row == '0) ? RW'(1) : eng_row - 1'b1;
  assign bot_row  = (eng_row == RW'(ROWS - 1)) ? RW'(ROWS - 2) : eng_row + 1'b1;
  assign need_row = (eng_row == RW'(ROWS - 1)) ? eng_row : eng_row + 1'b1;
  assign rows_ok  = in_done || ({1'b0, wr_row} > {1'b0, need_row});
  assign issue    = adv && rows_ok;
  assign frame_wrap = issue && (eng_j == CW'(COLS + 1)) && (eng_row == RW'(ROWS - 1));

  // read sweep: reflected column 1, then 0..COLS-1, then reflected COLS-2
  assign rd_col = (eng_j == '0)            ? MAW'(1) :
                  (eng_j == CW'(COLS + 1)) ? MAW'(COLS - 2) :
                                             MAW'(eng_j - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_row <= '0;
      eng_j   <= '0;
    end else if (issue) begin
      if (eng_j == CW'(COLS + 1)) begin
        eng_j   <= '0;
        eng_row <= (eng_row == RW'(ROWS - 1)) ? '0 : eng_row + 1'b1;
      end else begin
        eng_j <= eng_j + 1'b1;
      end
    end
  end

  // stage 1: line read in flight
  logic           s1_v;
  logic [CW-1:0]  s1_j;
  logic [RW-1:0]  s1_row;
  logic [SLW-1:0] s1_top, s1_mid, s1_bot;
  // stage 2: window holds columns s1_j-2..s1_j
  logic           s2_v;
  logic [CW-1:0]  s2_j;
  logic [RW-1:0]  s2_row;
  logic [2:0][2:0][DW-1:0] win;
  logic [2:0][DW-1:0]      col_new;

  assign col_new[0] = rd[s1_top];
  assign col_new[1] = rd[s1_mid];
  assign col_new[2] = rd[s1_bot];

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else if (adv) begin
      s1_v <= issue;
      s2_v <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_j   <= eng_j;
      s1_row <= eng_row;
      s1_top <= top_row[SLW-1:0];
      s1_mid <= eng_row[SLW-1:0];
      s1_bot <= bot_row[SLW-1:0];
      if (s1_v) begin
        s2_j   <= s1_j;
        s2_row <= s1_row;
        for (int r = 0; r < 3; r++) begin
          win[r][0] <= win[r][1];
          win[r][1] <= win[r][2];
          win[r][2] <= col_new[r];
        end
      end
    end
  end

  // ---------------- output stage ----------------
  logic [3*DW-1:0] rgb;
  site_e           site;
  assign site = site_e'({s2_row[0], s2_j[0]});

  bayer_kernel #(.DW(DW)) u_kernel (
    .win  (win),
    .site (site),
    .rgb  (rgb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (adv) begin
      out_valid <= s2_v && (s2_j >= CW'(2));
    end
  end

  always_ff @(posedge clk) begin
    if (adv) out_data <= rgb;
  end

  // ---------------- checks ----------------
  logic [RW-1:0] chk_row;
  logic [CW-1:0] chk_col;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_row <= '0;
      chk_col <= '0;
    end else if (out_valid && out_ready) begin
      if (chk_col == CW'(COLS - 1)) begin
        chk_col <= '0;
        chk_row <= (chk_row == RW'(ROWS - 1)) ? '0 : chk_row + 1'b1;
      end else begin
        chk_col <= chk_col + 1'b1;
      end
    end
  end

  // R6: a blocked word is held
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10: state right after reset
  a_r10_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && in_ready));

  // R8: an output row never overtakes the input row below it
  a_r8_rows_ready: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (in_done || (chk_row == RW'(ROWS - 1)) ||
                   ({1'b0, wr_row} > ({1'b0, chk_row} + 1'b1))));
endmodule

// File: tb/sim_bayer_demosaic.sv
`timescale 1ns/1ps
module sim_bayer_demosaic;
  localparam int ROWS = 30;
  localparam int COLS = 40;
  localparam int NPIX = ROWS * COLS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] out_data;

  int checks = 0;
  int errors = 0;
  int accepted_cnt = 0;
  logic [7:0] img [2][NPIX];

  always #2.5 clk = ~clk;

  bayer_demosaic #(.ROWS(ROWS), .COLS(COLS), .DW(8)) u0 (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int px(int f, int r, int c);
    int rr = (r < 0) ? -r : (r >= ROWS) ? 2 * ROWS - 2 - r : r;
    int cc = (c < 0) ? -c : (c >= COLS) ? 2 * COLS - 2 - c : c;
    return int'(img[f][rr * COLS + cc]);
  endfunction

  function automatic logic [23:0] exp_rgb(int f, int r, int c);
    int ctr = px(f, r, c);
    int cr  = (px(f, r-1, c) + px(f, r+1, c) + px(f, r, c-1) + px(f, r, c+1)) >> 2;
    int dg  = (px(f, r-1, c-1) + px(f, r-1, c+1) + px(f, r+1, c-1) + px(f, r+1, c+1)) >> 2;
    int hz  = (px(f, r, c-1) + px(f, r, c+1)) >> 1;
    int vt  = (px(f, r-1, c) + px(f, r+1, c)) >> 1;
    logic [7:0] rv, gv, bv;
    if (r % 2 == 0 && c % 2 == 0)      begin rv = 8'(ctr); gv = 8'(cr);  bv = 8'(dg);  end
    else if (r % 2 == 0)               begin rv = 8'(hz);  gv = 8'(ctr); bv = 8'(vt);  end
    else if (c % 2 == 0)               begin rv = 8'(vt);  gv = 8'(ctr); bv = 8'(hz);  end
    else                               begin rv = 8'(dg);  gv = 8'(cr);  bv = 8'(ctr); end
    return {rv, gv, bv};
  endfunction

  function automatic string tag_of(int r, int c);
    if (r == 0 || c == 0 || r == ROWS-1 || c == COLS-1) return "R4";
    if (r % 2 == 0 && c % 2 == 0) return "R1";
    if (r % 2 == 1 && c % 2 == 1) return "R2";
    return "R3";
  endfunction

  task automatic fill(input int f, input int kind);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        logic [7:0] v;
        case (kind)
          0: v = 8'((r * 37 + c * 11 + r * c * 5) & 255);
          1: v = (r % 2 == 0 && c % 2 == 0) ? 8'd200 :
                 (r % 2 == 1 && c % 2 == 1) ? 8'd40 : 8'd100;
          2: v = 8'hFF;
          default: v = 8'((r * 91 + c * c * 7 + 13) & 255);
        endcase
        img[f][r * COLS + c] = v;
      end
  endtask

  task automatic send_frame(input int f, input int gaps);
    int idx = 0;
    int cyc = 0;
    while (idx < NPIX) begin
      bit fire;
      @(negedge clk);
      in_valid = !(gaps != 0 && cyc % 3 == 2);
      in_data  = img[f][idx];
      fire = in_valid && in_ready;
      cyc++;
      @(posedge clk);
      if (fire) begin idx++; accepted_cnt++; end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic recv_frame(input int f, input int mode, input int hold, input bit first);
    int got = 0;
    int cyc = 0;
    bit seen = 0;
    logic [23:0] held;
    if (hold > 0) begin
      out_ready = 1'b0;
      repeat (hold / 2) @(negedge clk);
      held = out_data;
      repeat (hold - hold / 2) @(negedge clk);
      chk(accepted_cnt == 3 * COLS, "R7", 32'(accepted_cnt), 32'(3 * COLS), "accepted while blocked");
      chk(!in_ready, "R7", 32'(in_ready), 32'd0, "in_ready while blocked");
      chk(out_valid && out_data == held, "R6", out_data, held, "held word");
      chk(out_data == exp_rgb(f, 0, 0), "R4", out_data, exp_rgb(f, 0, 0), "corner word while blocked");
    end
    while (got < NPIX) begin
      @(negedge clk);
      case (mode)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 4 != 0);
        default: out_ready = ((cyc * 7 + cyc / 5) % 3 != 0);
      endcase
      if (first && out_valid && !seen) begin
        seen = 1;
        chk(accepted_cnt >= 2 * COLS, "R8", 32'(accepted_cnt), 32'(2 * COLS), "inputs before first output");
      end
      if (out_valid && out_ready) begin
        logic [23:0] e = exp_rgb(f, got / COLS, got % COLS);
        chk(out_data == e, tag_of(got / COLS, got % COLS), out_data, e, "pixel");
        got++;
      end
      cyc++;
    end
  endtask

  task automatic drain_check();
    bit extra = 0;
    out_ready = 1'b1;
    repeat (30) begin
      @(negedge clk);
      if (out_valid) extra = 1;
    end
    chk(!extra, "R5", 32'(extra), 32'd0, "words beyond frame");
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R10", 32'(out_valid), 32'd0, "out_valid after reset");
    chk(in_ready, "R10", 32'(in_ready), 32'd1, "in_ready after reset");
  endtask

  task automatic t_basic();
    fill(0, 0);
    accepted_cnt = 0;
    fork
      send_frame(0, 0);
      recv_frame(0, 0, 0, 1);
    join
    drain_check();
  endtask

  task automatic t_flat_phase();
    // R4: reflection keeps each phase constant, so every word is {200,100,40}
    fill(0, 1);
    accepted_cnt = 0;
    fork
      send_frame(0, 1);
      recv_frame(0, 1, 0, 1);
    join
    drain_check();
  endtask

  task automatic t_saturate();
    fill(0, 2);
    accepted_cnt = 0;
    fork
      send_frame(0, 0);
      recv_frame(0, 2, 0, 1);
    join
    drain_check();
  endtask

  task automatic t_stall();
    fill(0, 0);
    accepted_cnt = 0;
    fork
      send_frame(0, 0);
      recv_frame(0, 0, 400, 1);
    join
    drain_check();
  endtask

  task automatic t_back_to_back();
    // R9: two unlike frames with no idle between them
    fill(0, 3);
    fill(1, 0);
    accepted_cnt = 0;
    fork
      begin send_frame(0, 0); send_frame(1, 1); end
      begin recv_frame(0, 2, 0, 1); recv_frame(1, 1, 0, 0); end
    join
    drain_check();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog: actual %0d expected %0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_flat_phase();
    t_saturate();
    t_reset();
    t_stall();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule